// File: doc/BRIEF.md
# I2C Bus Master with Chained Transfer Descriptors

This block drives an I2C bus as its only master. Software fills a small queue with descriptors, each holding one byte and a flag that marks the end of a transfer. It then writes the command inputs with the start bit and the master select set. The block issues a START condition and sends the first descriptor as the address byte. It then either keeps sending the following descriptors as data, or turns the bus around and receives one byte for each following descriptor. The ninth clock of every byte is the acknowledge slot.

Descriptors are consumed one after another with no further command until a descriptor with its end flag set has been handled. The block then issues a STOP, drops busy and clears its start bit. If an addressed receiver leaves SDA high in the acknowledge slot, the block pulses an error output, empties the queue and closes the bus with a STOP. An optional bit-reversed mode sends and receives every byte least-significant bit first. Both lines are open-drain: the block only pulls a line low or releases it.

Top module: `i2c_desc_master`

## Requirements
- R1: While rst_ni is low and after reset, both line pull-downs are off, busy_o is low and neither nack_err_o nor rx_valid_o is asserted.
- R2: A transfer begins only when the stored start bit and master select are both set while idle. It opens with exactly one START condition, in which SDA falls while SCL is high. With master select clear, the bus stays released and busy_o stays low.
- R3: The first descriptor of a transfer is sent as the address byte. In normal mode its bit 0 is the R/W request (0 write, 1 read), and bits go out msb first. Every byte takes nine SCL pulses. On a write, all bytes reach the bus in queue order, and an all-zero address with R/W = 0 (general call) is sent like any other write.
- R4: A descriptor with its end flag clear is followed by the next one without any new command. After the descriptor whose end flag is set, the block sends a STOP, lowers busy_o and clears its start bit. Descriptors still queued are not sent until the start bit is written again.
- R5: When the address carries R/W = 1 and is acknowledged, the block releases SDA for the data bits and receives one byte per further descriptor. Each byte is presented on rx_data_o with a one-cycle rx_valid_o pulse. The block acknowledges every received byte except the one from the end-flagged descriptor, which it leaves unacknowledged before the STOP.
- R6: With the reverse bit set in the command, every byte moves lsb first in both directions. The R/W request is therefore taken from bit 7 of the stored address byte.
- R7: A missing acknowledge to any byte the block transmits gives a one-cycle nack_err_o pulse, flushes every queued descriptor and ends with a STOP. busy_o then drops, and the start bit must be written again.
- R8: SDA changes while SCL is high only for START (falling) and STOP (rising).
- R9: Every SCL high phase and every SCL low phase lasts at least div_i+1 clock cycles.
- R10: The queue holds DEPTH descriptors. A load while it is full is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_wr_i | input | 1 | Writes the command bits; ignored while busy |
| cmd_start_i | input | 1 | Start bit value |
| cmd_master_i | input | 1 | Master select value (1 = master) |
| cmd_rev_i | input | 1 | Reverse (lsb-first) data mode |
| div_i | input | DIV_W | Clock divider; one quarter bit lasts div_i+1 cycles |
| desc_wr_i | input | 1 | Pushes one descriptor into the queue |
| desc_data_i | input | 8 | Descriptor byte |
| desc_last_i | input | 1 | Descriptor end-of-transfer flag |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| busy_o | output | 1 | A transfer is in progress |
| nack_err_o | output | 1 | One-cycle pulse on a missing acknowledge |
| rx_valid_o | output | 1 | One-cycle pulse when a received byte is ready |
| rx_data_o | output | 8 | Last received byte |

## Verification
The bench uses the defaults DEPTH=4 and DIV_W=8, and it sets div_i between 0 and 4 for each transfer. A depth of four is enough to overfill the queue in one step, and to hold two complete end-flagged transfers at once, which exercises the re-arm rule. Small divider values keep each byte under two hundred cycles, so many randomized reads, writes and error cases fit in a run. A value of zero also checks the shortest allowed SCL phases.

// File: rtl/i2c_dm_pkg.sv
package i2c_dm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_LOAD, ST_BIT, ST_ACK, ST_STOP
  } state_e;

  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } desc_t;
endpackage

// File: rtl/i2c_dm_fifo.sv
module i2c_dm_fifo
  import i2c_dm_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  push_i,
  input  desc_t din_i,
  input  logic  pop_i,
  input  logic  flush_i,
  output desc_t dout_o,
  output logic  empty_o,
  output logic  full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  desc_t          mem_q [DEPTH];
  logic [AW-1:0]  wr_q, rd_q;
  logic [CW-1:0]  cnt_q;
  logic           push_ok, pop_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
  assign push_ok = push_i && !full_o;
  assign pop_ok  = pop_i && !empty_o;
  assign dout_o  = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem_q[wr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      unique case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: ;
      endcase
    end
  end

  p_cnt_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_full_drop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (full_o && $stable(wr_q)));
endmodule

// File: rtl/i2c_dm_tick.sv
module i2c_dm_tick #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/i2c_desc_master.sv
module i2c_desc_master
  import i2c_dm_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_wr_i,
  input  logic             cmd_start_i,
  input  logic             cmd_master_i,
  input  logic             cmd_rev_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             desc_wr_i,
  input  logic [7:0]       desc_data_i,
  input  logic             desc_last_i,
  input  logic             sda_i,
  output logic             scl_oe_o,
  output logic             sda_oe_o,
  output logic             busy_o,
  output logic             nack_err_o,
  output logic             rx_valid_o,
  output logic [7:0]       rx_data_o
);
  localparam int HW = DIV_W + 2;

  state_e      state_q;
  logic [1:0]  q_q;
  logic [2:0]  bit_q;
  logic [7:0]  sh_q, rx_q;
  logic        last_q, first_q, rw_q, rd_q;
  logic        start_q, master_q, rev_q;
  logic        err_q, rxv_q;
  logic        tick, run, q_empty, q_full, pop, flush, tx_bit;
  desc_t       head, din;

  assign din  = '{last: desc_last_i, data: desc_data_i};
  assign run  = (state_q != ST_IDLE) && (state_q != ST_LOAD);
  assign pop  = (state_q == ST_LOAD) && !q_empty;
  assign flush = (state_q == ST_ACK) && tick && (q_q == 2'd3) && !rd_q && sda_i;
  assign tx_bit = rev_q ? sh_q[0] : sh_q[7];

  i2c_dm_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i, .rst_ni, .push_i(desc_wr_i), .din_i(din), .pop_i(pop),
    .flush_i(flush), .dout_o(head), .empty_o(q_empty), .full_o(q_full)
  );

  i2c_dm_tick #(.DIV_W(DIV_W)) u_tick (
    .clk_i, .rst_ni, .run_i(run), .div_i, .tick_o(tick)
  );

  // quarter 0/1: SCL low, quarter 2/3: SCL high
  always_comb begin
    scl_oe_o = 1'b0;
    sda_oe_o = 1'b0;
    unique case (state_q)
      ST_START: begin scl_oe_o = (q_q == 2'd3); sda_oe_o = (q_q != 2'd0); end
      ST_LOAD:  scl_oe_o = 1'b1;
      ST_BIT:   begin scl_oe_o = !q_q[1]; sda_oe_o = !rd_q && !tx_bit; end
      ST_ACK:   begin scl_oe_o = !q_q[1]; sda_oe_o = rd_q && !last_q; end
      ST_STOP:  begin scl_oe_o = !q_q[1]; sda_oe_o = (q_q != 2'd3); end
      default:  ;
    endcase
  end

  assign busy_o     = (state_q != ST_IDLE);
  assign nack_err_o = err_q;
  assign rx_valid_o = rxv_q;
  assign rx_data_o  = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;  q_q <= '0;     bit_q <= '0;
      sh_q <= '0;          rx_q <= '0;    last_q <= 1'b0;
      first_q <= 1'b0;     rw_q <= 1'b0;  rd_q <= 1'b0;
      start_q <= 1'b0;     master_q <= 1'b0; rev_q <= 1'b0;
      err_q <= 1'b0;       rxv_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      rxv_q <= 1'b0;
      if (cmd_wr_i && state_q == ST_IDLE) begin
        start_q  <= cmd_start_i;
        master_q <= cmd_master_i;
        rev_q    <= cmd_rev_i;
      end
      unique case (state_q)
        ST_IDLE: if (start_q && master_q) begin
          state_q <= ST_START; q_q <= '0; first_q <= 1'b1; rd_q <= 1'b0;
        end
        ST_START: if (tick) begin
          q_q <= q_q + 2'd1;
          if (q_q == 2'd3) state_q <= ST_LOAD;
        end
        ST_LOAD: if (!q_empty) begin
          sh_q   <= head.data;
          last_q <= head.last;
          if (first_q) rw_q <= rev_q ? head.data[7] : head.data[0];
          bit_q <= '0; q_q <= '0; state_q <= ST_BIT;
        end
        ST_BIT: if (tick) begin
          q_q <= q_q + 2'd1;
          if (q_q == 2'd3) begin
            rx_q  <= rev_q ? {sda_i, rx_q[7:1]} : {rx_q[6:0], sda_i};
            sh_q  <= rev_q ? {1'b0, sh_q[7:1]} : {sh_q[6:0], 1'b0};
            bit_q <= bit_q + 3'd1;
            if (bit_q == 3'd7) state_q <= ST_ACK;
          end
        end
        ST_ACK: if (tick) begin
          q_q <= q_q + 2'd1;
          if (q_q == 2'd3) begin
            first_q <= 1'b0;
            if (rd_q) begin
              rxv_q   <= 1'b1;
              state_q <= last_q ? ST_STOP : ST_LOAD;
            end else if (sda_i) begin
              err_q   <= 1'b1;
              state_q <= ST_STOP;
            end else begin
              if (first_q && rw_q) rd_q <= 1'b1;
              state_q <= last_q ? ST_STOP : ST_LOAD;
            end
          end
        end
        ST_STOP: if (tick) begin
          q_q <= q_q + 2'd1;
          if (q_q == 2'd3) begin
            state_q <= ST_IDLE; start_q <= 1'b0; rd_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // checker: length of the current SCL released run
  logic [HW-1:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           hi_run_q <= '0;
    else if (scl_oe_o)     hi_run_q <= '0;
    else if (~&hi_run_q)   hi_run_q <= hi_run_q + HW'(1);
  end

  p_sda_fall_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && $past(!scl_oe_o) && $rose(sda_oe_o)) |-> state_q == ST_START);
  p_sda_rise_hi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!scl_oe_o && $past(!scl_oe_o) && $fell(sda_oe_o)) |-> state_q == ST_STOP);
  p_go_needs_cmd_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> ($past(start_q) && $past(master_q)));
  p_err_flush_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_err_o |-> (state_q == ST_STOP && q_empty));
  p_err_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nack_err_o |=> !nack_err_o);
  p_rx_in_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> rd_q);
  p_scl_high_len_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $rose(scl_oe_o)) |-> hi_run_q >= {2'b00, div_i} + HW'(1));
endmodule

// File: tb/i2c_desc_master_test.sv
module i2c_desc_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int DIV_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic cmd_wr = 0, cmd_start = 0, cmd_master = 0, cmd_rev = 0;
  logic [DIV_W-1:0] div = '0;
  logic desc_wr = 0, desc_last = 0;
  logic [7:0] desc_data = '0;
  logic scl_oe, sda_oe, busy, nack_err, rx_valid;
  logic [7:0] rx_data;
  logic slv_pull = 1'b0;
  wire scl_bus = !scl_oe;
  wire sda_bus = !(sda_oe || slv_pull);

  i2c_desc_master #(.DEPTH(DEPTH), .DIV_W(DIV_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_wr_i(cmd_wr), .cmd_start_i(cmd_start),
    .cmd_master_i(cmd_master), .cmd_rev_i(cmd_rev), .div_i(div),
    .desc_wr_i(desc_wr), .desc_data_i(desc_data), .desc_last_i(desc_last),
    .sda_i(sda_bus), .scl_oe_o(scl_oe), .sda_oe_o(sda_oe), .busy_o(busy),
    .nack_err_o(nack_err), .rx_valid_o(rx_valid), .rx_data_o(rx_data)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rev8(logic [7:0] b);
    for (int i = 0; i < 8; i++) rev8[i] = b[7-i];
  endfunction

  // slave model and monitors
  int bitn = 0, byten = 0, n_log = 0, n_mack = 0, starts = 0, stops = 0;
  int nack_at = -1, txi = 0, n_err = 0, n_rx = 0;
  int run_len = 0, min_lo = 1000000, min_hi = 1000000;
  logic [7:0] sbyte = '0, cur_tx = '0;
  bit slv_rd = 0, p_scl = 1, p_sda = 1;
  logic [7:0] wire_log [16];
  logic [7:0] rx_log [16];
  logic [7:0] tx_pat [8];
  bit mack_log [16];

  always @(negedge clk) begin
    bit s, d;
    s = scl_bus;
    d = sda_bus;
    if (!rst_n) begin
      p_scl = 1; p_sda = 1; slv_pull = 0; bitn = 0; slv_rd = 0; run_len = 0;
    end else begin
      if (nack_err) n_err++;
      if (rx_valid) begin rx_log[n_rx % 16] = rx_data; n_rx++; end
      if (p_scl && s && p_sda && !d) begin
        starts++; bitn = 0; byten = 0; slv_rd = 0; slv_pull = 0;
      end else if (p_scl && s && !p_sda && d) begin
        stops++;
      end else if (!p_scl && s) begin
        if (bitn < 8) begin
          if (!slv_rd) sbyte = {sbyte[6:0], d};
          bitn++;
        end else if (bitn == 8) begin
          if (slv_rd) begin mack_log[n_mack % 16] = !d; n_mack++; end
          bitn = 9;
        end
      end else if (p_scl && !s) begin
        if (bitn == 8) begin
          if (!slv_rd) begin
            wire_log[n_log % 16] = sbyte; n_log++;
            slv_pull = (byten != nack_at);
          end else slv_pull = 0;
        end else if (bitn == 9) begin
          slv_pull = 0; bitn = 0;
          if (!slv_rd && byten == 0 && sbyte[0] && nack_at != 0) begin
            slv_rd = 1; cur_tx = tx_pat[txi % 8]; txi++; slv_pull = !cur_tx[7];
          end else if (slv_rd && n_mack > 0 && mack_log[(n_mack-1) % 16]) begin
            cur_tx = tx_pat[txi % 8]; txi++; slv_pull = !cur_tx[7];
          end
          byten++;
        end else if (slv_rd && bitn >= 1 && bitn <= 7) begin
          slv_pull = !cur_tx[7-bitn];
        end
      end
      if (s == p_scl) run_len++;
      else begin
        if (p_scl) begin if (run_len < min_hi) min_hi = run_len; end
        else if (run_len < min_lo) min_lo = run_len;
        run_len = 1;
      end
      p_scl = s;
      p_sda = d;
    end
  end

  task automatic push_desc(logic [7:0] b, bit l);
    @(negedge clk);
    desc_wr = 1; desc_data = b; desc_last = l;
    @(negedge clk);
    desc_wr = 0;
  endtask

  task automatic write_cmd(bit st, bit ms, bit rv);
    @(negedge clk);
    cmd_wr = 1; cmd_start = st; cmd_master = ms; cmd_rev = rv;
    @(negedge clk);
    cmd_wr = 0;
  endtask

  task automatic wait_idle();
    repeat (3) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_logs();
    n_log = 0; n_mack = 0; n_rx = 0; txi = 0; min_lo = 1000000; min_hi = 1000000;
  endtask

  // one full transfer: address + nb descriptors, slave nacks byte index nk (-1 none)
  task automatic do_xfer(bit rev, int dv, bit rd, int nb, int nk, logic [6:0] addr);
    logic [7:0] wb [8];
    int s0, p0, e0, exp_log;
    bit exp_err;
    s0 = starts; p0 = stops; e0 = n_err;
    clear_logs();
    nack_at = nk;
    div = DIV_W'(dv);
    wb[0] = {addr, rd};
    for (int i = 1; i <= nb; i++) begin
      wb[i] = 8'($urandom);
      tx_pat[i-1] = 8'($urandom);
    end
    for (int i = 0; i <= nb; i++) push_desc(rev ? rev8(wb[i]) : wb[i], i == nb);
    write_cmd(1, 1, rev);
    wait_idle();
    exp_err = (nk >= 0);
    exp_log = rd ? 1 : (nk >= 0 ? nk + 1 : nb + 1);
    chk(starts == s0 + 1, "R2 one START", starts - s0, 1);
    chk(stops == p0 + 1, "R4 one STOP", stops - p0, 1);
    chk(busy == 0, "R4 busy low after end", busy, 0);
    chk(n_err - e0 == int'(exp_err), "R7 nack error pulses", n_err - e0, exp_err);
    chk(n_log == exp_log, "R3 bytes seen by receiver", n_log, exp_log);
    for (int i = 0; i < exp_log && i < n_log; i++)
      chk(wire_log[i] == wb[i], rev ? "R6 reversed byte on wire" : "R3 byte on wire",
          wire_log[i], wb[i]);
    if (rd && nk < 0) begin
      chk(n_rx == nb, "R5 received byte count", n_rx, nb);
      for (int i = 0; i < nb && i < n_rx; i++)
        chk(rx_log[i] == (rev ? rev8(tx_pat[i]) : tx_pat[i]),
            rev ? "R6 reversed read data" : "R5 read data", rx_log[i],
            rev ? rev8(tx_pat[i]) : tx_pat[i]);
      chk(n_mack == nb, "R5 master ack slots", n_mack, nb);
      for (int i = 0; i < nb && i < n_mack; i++)
        chk(mack_log[i] == (i < nb - 1), "R5 ack all but last", mack_log[i], i < nb - 1);
    end
    if (rd && nk == 0) chk(n_rx == 0, "R7 no read after address nack", n_rx, 0);
    chk(min_lo >= dv + 1, "R9 SCL low phase", min_lo, dv + 1);
    chk(min_hi >= dv + 1, "R9 SCL high phase", min_hi, dv + 1);
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int s0, p0;
    void'($urandom(32'h5eed_1c2a));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(scl_oe == 0 && sda_oe == 0, "R1 lines released in reset", {scl_oe, sda_oe}, 0);
    chk(busy == 0 && nack_err == 0 && rx_valid == 0, "R1 status in reset",
        {busy, nack_err, rx_valid}, 0);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0 && busy == 0, "R1 idle after reset",
        {scl_oe, sda_oe, busy}, 0);

    // R2: start without master select
    s0 = starts;
    write_cmd(1, 0, 0);
    repeat (200) @(negedge clk);
    chk(busy == 0, "R2 no transfer without master", busy, 0);
    chk(starts == s0, "R2 no START without master", starts - s0, 0);
    write_cmd(0, 0, 0);

    // directed cases
    do_xfer(0, 1, 0, 3, -1, 7'h5a);     // R3 write, R4 chaining
    do_xfer(0, 0, 0, 2, -1, 7'h00);     // R3 general call, fastest divider
    do_xfer(0, 2, 1, 3, -1, 7'h21);     // R5 read
    do_xfer(1, 1, 0, 2, -1, 7'h4c);     // R6 reversed write
    do_xfer(1, 0, 1, 2, -1, 7'h13);     // R6 reversed read
    do_xfer(0, 1, 0, 3, 2, 7'h30);      // R7 nack on data, tail flushed
    do_xfer(0, 1, 0, 1, -1, 7'h31);     // R7 follow-up sends only fresh bytes
    do_xfer(0, 1, 1, 2, 0, 7'h44);      // R7 nack on read address
    do_xfer(0, 1, 0, 1, 0, 7'h45);      // R7 nack on write address
    do_xfer(0, 1, 1, 1, -1, 7'h46);     // R5 single read byte

    // R4: end flag stops; second queued transfer needs a new start
    clear_logs(); nack_at = -1; div = 8'd1;
    s0 = starts; p0 = stops;
    push_desc(8'hA0, 0); push_desc(8'h11, 1);
    push_desc(8'hB2, 0); push_desc(8'h22, 1);
    write_cmd(1, 1, 0);
    wait_idle();
    repeat (300) @(negedge clk);
    chk(starts == s0 + 1, "R4 halts after end flag", starts - s0, 1);
    chk(busy == 0, "R4 idle until rearmed", busy, 0);
    chk(n_log == 2 && wire_log[1] == 8'h11, "R4 first transfer bytes", n_log, 2);
    clear_logs();
    write_cmd(1, 1, 0);
    wait_idle();
    chk(starts == s0 + 2 && stops == p0 + 2, "R4 second START after rearm", starts - s0, 2);
    chk(n_log == 2 && wire_log[0] == 8'hB2 && wire_log[1] == 8'h22,
        "R4 queued transfer sent", wire_log[0], 8'hB2);

    // R10: queue overfill drops the extra load
    clear_logs();
    push_desc(8'hC4, 0); push_desc(8'h01, 0); push_desc(8'h02, 0);
    push_desc(8'h03, 1); push_desc(8'hEE, 1);
    write_cmd(1, 1, 0);
    wait_idle();
    chk(n_log == DEPTH, "R10 queue holds DEPTH", n_log, DEPTH);
    do_xfer(0, 1, 0, 1, -1, 7'h6d);     // R10 dropped entry must not appear

    // randomized mix
    for (int it = 0; it < 14; it++) begin
      bit rv, rdm;
      int nb, nk, dv;
      rv  = 1'($urandom);
      rdm = 1'($urandom);
      nb  = 1 + int'($urandom_range(0, DEPTH - 2));
      dv  = int'($urandom_range(0, 4));
      nk  = -1;
      if ($urandom_range(0, 3) == 0) nk = rdm ? 0 : int'($urandom_range(0, nb));
      do_xfer(rv, dv, rdm, nb, nk, 7'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule